// File: doc/BRIEF.md
# Saturating Half-Word Left Shifter

This unit takes one signed 16-bit half of a 32-bit source word and shifts it left by an immediate count. The count is 5 bits wide. If the exact product no longer fits in a signed 16-bit value, the result is clamped to the nearest limit, 0x7FFF or 0x8000, and an overflow flag is raised. The 16-bit result replaces one half of a 32-bit destination word. The other half of that word is passed through from the old destination value.

The source half and the destination half are chosen independently. This covers all four lane pairings: low to low, low to high, high to low and high to high.

The unit is built for an execute stage. By default the new destination word and the flag are registered and load on a clock edge that samples the valid strobe high. A parameter instead gives a purely combinational path from inputs to outputs.

Top module: `hsat_shift`

## Requirements
- R1: With `src_hi`=0 the operand is `src_word[15:0]`; with `src_hi`=1 it is `src_word[31:16]`. The operand is treated as two's-complement signed.
- R2: With `dst_hi`=0 the result lands in `dst_new[15:0]` and `dst_new[31:16]` equals `dst_old[31:16]`. With `dst_hi`=1 the result lands in `dst_new[31:16]` and `dst_new[15:0]` equals `dst_old[15:0]`.
- R3: A non-negative operand whose shifted value exceeds 32767 gives 0x7FFF with `ovf`=1 (for example, 0x000F shifted by 12 gives 0x7FFF).
- R4: A negative operand whose shifted value falls below -32768 gives 0x8000 with `ovf`=1 (for example, 0xD001 shifted by 8 gives 0x8000).
- R5: When the shifted value fits, the result is the exact value with zeros entering from the right, and `ovf`=0 (for example, 0xC001 shifted by 1 gives 0x8002, and 0x0001 shifted by 9 gives 0x0200).
- R6: A count of 0 returns the operand unchanged, 0x8000 included, with `ovf`=0.
- R7: An operand of 0 gives 0 with `ovf`=0 for every count.
- R8: For counts from 16 to 31, a nonzero operand saturates according to its sign with `ovf`=1, and a zero operand gives 0.
- R9: In registered mode, `dst_new` and `ovf` load on a rising edge where `in_vld`=1 and hold their values on every edge where `in_vld`=0.
- R10: A synchronous `rst` clears `dst_new` and `ovf` to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used in registered mode) |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe; loads the output register |
| src_word | input | 32 | Word that supplies the operand half |
| dst_old | input | 32 | Previous destination word |
| src_hi | input | 1 | Operand half select: 0 = low, 1 = high |
| dst_hi | input | 1 | Result half select: 0 = low, 1 = high |
| shamt | input | 5 | Left shift count |
| dst_new | output | 32 | Updated destination word |
| ovf | output | 1 | High when saturation replaced the exact result |

## Verification
The combinational checks assume that all inputs are known, 2-state values at the moment they are evaluated. The register checks assume that `in_vld` and the data inputs change only between clock edges.

The bench drives every input on the falling edge and raises `in_vld` for exactly one rising edge per operation. It samples the outputs on the following falling edge.

Random counts cover the full 5-bit range, so the counts of 16 and above that R8 covers are exercised. The random operand generator deliberately favours values near the sign boundary and narrow operands, so that both saturated and exact results occur often.

// File: rtl/hss_pkg.sv
package hss_pkg;
   typedef enum logic {
      LANE_LO = 1'b0,
      LANE_HI = 1'b1
   } lane_e;
endpackage

// File: rtl/hss_lane_pick.sv
module hss_lane_pick
   import hss_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] word,
   input  lane_e               lane,
   output logic [HALF_W-1:0]   half
);
   always_comb begin
      unique case (lane)
         LANE_HI: half = word[2*HALF_W-1:HALF_W];
         default: half = word[HALF_W-1:0];
      endcase
   end

   // R1: the picked half matches the word slice for the selected lane
   always_comb begin
      if (lane == LANE_HI)
         p_pick_hi_r1: assert (half == word[2*HALF_W-1:HALF_W]);
   end
endmodule

// File: rtl/hss_sat_core.sv
module hss_sat_core #(
   parameter int HALF_W = 16,
   parameter int CNT_W  = 5
) (
   input  logic [HALF_W-1:0] operand,
   input  logic [CNT_W-1:0]  shamt,
   output logic [HALF_W-1:0] result,
   output logic              ovf
);
   localparam int MAX_SH = (1 << CNT_W) - 1;
   localparam int WIDE   = HALF_W + MAX_SH + 1;
   localparam int TOP_W  = WIDE - HALF_W + 1;
   localparam logic [HALF_W-1:0] POS_LIM = {1'b0, {(HALF_W-1){1'b1}}};
   localparam logic [HALF_W-1:0] NEG_LIM = {1'b1, {(HALF_W-1){1'b0}}};

   logic              sgn;
   logic [WIDE-1:0]   ext;
   logic [WIDE-1:0]   shifted;
   logic [TOP_W-1:0]  top;
   logic              fits;

   assign sgn     = operand[HALF_W-1];
   assign ext     = {{(WIDE-HALF_W){sgn}}, operand};
   assign shifted = ext << shamt;
   assign top     = shifted[WIDE-1:HALF_W-1];
   assign fits    = (&top) | ~(|top);
   assign ovf     = ~fits;
   assign result  = fits ? shifted[HALF_W-1:0] : (sgn ? NEG_LIM : POS_LIM);

   always_comb begin
      // R3: a saturated non-negative operand yields the positive limit
      if (ovf && !operand[HALF_W-1])
         p_pos_sat_r3: assert (result == POS_LIM);
      // R4: a saturated negative operand yields the negative limit
      if (ovf && operand[HALF_W-1])
         p_neg_sat_r4: assert (result == NEG_LIM);
      // R6: a zero count passes the operand through
      if (shamt == '0)
         p_zero_count_r6: assert (result == operand && !ovf);
      // R7: a zero operand never saturates
      if (operand == '0)
         p_zero_operand_r7: assert (result == '0 && !ovf);
      // R5: an exact result keeps the sign of the operand
      if (!ovf && operand != '0)
         p_exact_sign_r5: assert (result[HALF_W-1] == operand[HALF_W-1] || result == '0);
   end
endmodule

// File: rtl/hss_lane_merge.sv
module hss_lane_merge
   import hss_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] old_word,
   input  logic [HALF_W-1:0]   half,
   input  lane_e               lane,
   output logic [2*HALF_W-1:0] new_word
);
   always_comb begin
      unique case (lane)
         LANE_HI: new_word = {half, old_word[HALF_W-1:0]};
         default: new_word = {old_word[2*HALF_W-1:HALF_W], half};
      endcase
   end

   // R2: the lane that is not written keeps the old contents
   always_comb begin
      if (lane == LANE_HI)
         p_keep_lo_r2: assert (new_word[HALF_W-1:0] == old_word[HALF_W-1:0]);
      else
         p_keep_hi_r2: assert (new_word[2*HALF_W-1:HALF_W] == old_word[2*HALF_W-1:HALF_W]);
   end
endmodule

// File: rtl/hsat_shift.sv
module hsat_shift
   import hss_pkg::*;
#(
   parameter int HALF_W     = 16,
   parameter int CNT_W      = 5,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_vld,
   input  logic [2*HALF_W-1:0] src_word,
   input  logic [2*HALF_W-1:0] dst_old,
   input  logic                src_hi,
   input  logic                dst_hi,
   input  logic [CNT_W-1:0]    shamt,
   output logic [2*HALF_W-1:0] dst_new,
   output logic                ovf
);
   localparam int WORD_W = 2 * HALF_W;

   if (HALF_W < 2) begin : g_bad_half
      $error("hsat_shift: HALF_W must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 6) begin : g_bad_cnt
      $error("hsat_shift: CNT_W must lie in 1..6");
   end

   logic [HALF_W-1:0] op_half;
   logic [HALF_W-1:0] res_half;
   logic              ovf_c;
   logic [WORD_W-1:0] word_c;

   hss_lane_pick #(.HALF_W(HALF_W)) u_pick (
      .word (src_word),
      .lane (lane_e'(src_hi)),
      .half (op_half)
   );

   hss_sat_core #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_core (
      .operand (op_half),
      .shamt   (shamt),
      .result  (res_half),
      .ovf     (ovf_c)
   );

   hss_lane_merge #(.HALF_W(HALF_W)) u_merge (
      .old_word (dst_old),
      .half     (res_half),
      .lane     (lane_e'(dst_hi)),
      .new_word (word_c)
   );

   if (REGISTERED) begin : g_reg
      logic [WORD_W-1:0] word_q;
      logic              ovf_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= '0;
            ovf_q  <= 1'b0;
         end else if (in_vld) begin
            word_q <= word_c;
            ovf_q  <= ovf_c;
         end
      end

      assign dst_new = word_q;
      assign ovf     = ovf_q;

      // R10: reset clears the output register
      p_reset_clear_r10: assert property (@(posedge clk)
         rst |=> (dst_new == '0 && !ovf));
      // R9: no strobe, no change
      p_hold_r9: assert property (@(posedge clk) disable iff (rst)
         !in_vld |=> ($stable(dst_new) && $stable(ovf)));
      // R9: a strobe captures the flag computed from the inputs
      p_load_r9: assert property (@(posedge clk) disable iff (rst)
         in_vld |=> (ovf == $past(ovf_c)));
   end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst, in_vld};
      assign dst_new    = word_c;
      assign ovf        = ovf_c;
   end
endmodule

// File: tb/hsat_shift_tb.sv
`timescale 1ns/1ps
module hsat_shift_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [31:0] src_word = '0;
   logic [31:0] dst_old = '0;
   logic        src_hi = 1'b0;
   logic        dst_hi = 1'b0;
   logic [4:0]  shamt = '0;
   logic [31:0] dst_new;
   logic        ovf;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   hsat_shift u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .src_word(src_word),
      .dst_old(dst_old), .src_hi(src_hi), .dst_hi(dst_hi), .shamt(shamt),
      .dst_new(dst_new), .ovf(ovf)
   );

   function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] o,
                                         input logic sh, input logic dh,
                                         input logic [4:0] n, output logic f);
      logic [15:0] h;
      longint      v;
      logic [15:0] r;
      h = sh ? s[31:16] : s[15:0];
      v = longint'($signed(h)) * (longint'(1) << n);
      if (v > 32767) begin
         r = 16'h7FFF; f = 1'b1;
      end else if (v < -32768) begin
         r = 16'h8000; f = 1'b1;
      end else begin
         r = v[15:0]; f = 1'b0;
      end
      return dh ? {r, o[15:0]} : {o[31:16], r};
   endfunction

   task automatic check(input string req, input logic [31:0] exp_w, input logic exp_f);
      n_cmp++;
      if (dst_new !== exp_w || ovf !== exp_f) begin
         n_bad++;
         $display("FAIL %s: got word=%08h ovf=%0b expected word=%08h ovf=%0b",
                  req, dst_new, ovf, exp_w, exp_f);
      end
   endtask

   task automatic run_op(input string req, input logic [31:0] s, input logic [31:0] o,
                         input logic sh, input logic dh, input logic [4:0] n);
      logic [31:0] ew;
      logic        ef;
      @(negedge clk);
      src_word = s; dst_old = o; src_hi = sh; dst_hi = dh; shamt = n; in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      ew = model(s, o, sh, dh, n, ef);
      check(req, ew, ef);
   endtask

   initial begin : wd
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] w_hold;
      logic        f_hold;
      repeat (3) @(negedge clk);
      check("R10 reset", 32'h0, 1'b0);
      rst = 1'b0;

      // directed cases
      run_op("R5 exact neg",      32'h1000C001, 32'h1000C001, 0, 0, 5'd1);
      check("R5 value", 32'h10008002, 1'b0);
      run_op("R5 exact pos",      32'h00000001, 32'h0000D003, 0, 1, 5'd9);
      check("R5 value hi", 32'h0200D003, 1'b0);
      run_op("R3 pos sat",        32'h0000000F, 32'h0000000F, 0, 1, 5'd12);
      check("R3 value", 32'h7FFF000F, 1'b1);
      run_op("R4 neg sat",        32'h0000D001, 32'hAAAA5555, 0, 1, 5'd8);
      check("R4 value", 32'h80005555, 1'b1);
      run_op("R6 zero count",     32'h00008000, 32'h00008000, 0, 1, 5'd0);
      check("R6 value", 32'h80008000, 1'b0);
      run_op("R7 zero operand",   32'h00005000, 32'h12345678, 1, 0, 5'd13);
      check("R7 value", 32'h12340000, 1'b0);
      run_op("R1 high source",    32'h00035000, 32'hFFFF0000, 1, 0, 5'd10);
      check("R1 value", 32'hFFFF0C00, 1'b0);
      run_op("R2 keep low",       32'h00000010, 32'h0000F001, 0, 1, 5'd13);
      check("R2 value", 32'h7FFFF001, 1'b1);
      run_op("R8 big count neg",  32'hFFFF0000, 32'h0, 1, 0, 5'd16);
      check("R8 value neg", 32'h00008000, 1'b1);
      run_op("R8 big count pos",  32'h00000001, 32'h0, 0, 0, 5'd31);
      check("R8 value pos", 32'h00007FFF, 1'b1);
      run_op("R8 big count zero", 32'h00000000, 32'h0, 0, 1, 5'd31);
      run_op("R5 minus one by 15", 32'h0000FFFF, 32'h0, 0, 0, 5'd15);
      check("R5 value edge", 32'h00008000, 1'b0);

      // R9: inputs change without a strobe, output holds
      w_hold = dst_new; f_hold = ovf;
      @(negedge clk);
      src_word = 32'h0000000F; dst_old = 32'hDEADBEEF; shamt = 5'd14;
      src_hi = 0; dst_hi = 0;
      repeat (3) @(negedge clk);
      check("R9 hold", w_hold, f_hold);

      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] s;
         logic [31:0] o;
         logic [15:0] h;
         logic [4:0]  n;
         int sel;
         s   = $urandom;
         o   = $urandom;
         sel = $urandom_range(0, 3);
         h   = s[15:0];
         if (sel == 0) h = h >> $urandom_range(0, 15);
         else if (sel == 1) h = ~(16'hFFFF >> $urandom_range(0, 15)) | (h & 16'h000F);
         s[15:0] = h;
         n = (i % 5 == 0) ? 5'($urandom_range(16, 31)) : 5'($urandom_range(0, 15));
         run_op("R1 R2 R3 R4 R5 R8 random", s, o, 1'($urandom), 1'($urandom), n);
      end

      // R10: reset in the middle of operation
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R10 mid reset", 32'h0, 1'b0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : seed
      process p;
      p = process::self();
      p.srandom(32'd20240611);
   end
endmodule